// File: doc/BRIEF.md
# Wake-capable interrupt sense controller

This block collects two families of wake sources and turns them into interrupts. Peripheral wake lines are always sensed as active-high levels. Each one drives its own output bit, and the bit index matches the input index. System-wake pins are first synchronised to the block clock. Each pin then has its own programmable sense mode, which can be rising edge, falling edge, both edges, active-high level or active-low level. All system-wake pins share one combined interrupt output. A wake request output stays high while any enabled source is asserting.

Software uses a small register port to program the block. The port has a write strobe, an address, write data and read data. A write takes effect at the clock edge where the strobe is high. Reads are combinational from the address. Two build-time counts set how many peripheral lines and how many system-wake pins are connected, up to eight of each. Lines above those counts are never instantiated, read as zero and can never assert.

Top module: `wake_sense_ctrl`

## Requirements
- R1: After reset, every register reads 0: sense codes, both enable masks and the edge status. All interrupt outputs and the wake request are low.
- R2: Peripheral output bit i follows peripheral input i. It is high only while input i is high, enable bit i (address 0x10) is set, and line i has been given a sense code.
- R3: A write of any data to the sense register of peripheral line i (address 0x00+i) sets that line's code to 4, active-high level. The register then reads back 4.
- R4: The sense register of system-wake line j is at address 0x08+j. It accepts only the byte values 0, 1, 2, 3, 4 and 8. A write of any other value leaves the stored code unchanged.
- R5: With code 1, a 0-to-1 change on an enabled system-wake pin sets status bit j (address 0x12). This happens three clock edges after the change: two synchroniser stages and one edge-detect stage. The set bit asserts the shared output.
- R6: With code 2, a 1-to-0 change on an enabled pin sets status bit j.
- R7: With code 3, a change in either direction sets status bit j.
- R8: Status bits are sticky. Writing 1 to a bit of address 0x12 clears that bit. Writing 0 to a bit leaves it unchanged.
- R9: Code 4 asserts the shared output only while the synchronised pin is high. Code 8 asserts it only while the pin is low. Neither level code sets a status bit.
- R10: A system-wake line whose enable bit (address 0x11) is clear, or whose code is 0, never sets status and never asserts the shared output.
- R11: Lines at or above the configured counts never assert any output or status bit. Their registers read 0, and their enable bits read 0.
- R12: The wake request is high exactly when any peripheral output bit or the shared system-wake output is high.
- R13: Addresses other than 0x00 to 0x12 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from the address |
| periph_in | input | 8 | Peripheral wake lines, active high |
| syswake_in | input | 8 | Asynchronous system-wake pins |
| periph_irq | output | 8 | Per-peripheral interrupt, same index as the input |
| syswake_irq | output | 1 | Shared system-wake interrupt |
| wake_req | output | 1 | Any enabled source asserting |

## Verification
The bench builds the block with five peripheral lines and six system-wake pins. This leaves the top lines of both families unconnected, so every sweep also shows that absent lines stay silent and read as zero. The bench covers every system-wake line with every legal sense code, with the line both enabled and disabled. For each combination it drives a rising and then a falling pin change and predicts the status and shared output from the code arithmetically. A separate sweep writes all sixteen low byte values to one sense register to reach the reject path.

// File: rtl/wsc_pkg.sv
package wsc_pkg;
   localparam int unsigned LINE_MAX = 8;
   localparam int unsigned CODE_W   = 4;

   typedef enum logic [CODE_W-1:0] {
      SNS_NONE = 4'd0,
      SNS_RISE = 4'd1,
      SNS_FALL = 4'd2,
      SNS_BOTH = 4'd3,
      SNS_HIGH = 4'd4,
      SNS_LOW  = 4'd8
   } sense_e;

   localparam logic [4:0] A_PMODE = 5'h00;
   localparam logic [4:0] A_SMODE = 5'h08;
   localparam logic [4:0] A_PEN   = 5'h10;
   localparam logic [4:0] A_SEN   = 5'h11;
   localparam logic [4:0] A_STAT  = 5'h12;

   function automatic logic code_ok(input logic [7:0] v);
      case (v)
         8'd0, 8'd1, 8'd2, 8'd3, 8'd4, 8'd8: code_ok = 1'b1;
         default:                            code_ok = 1'b0;
      endcase
   endfunction
endpackage

// File: rtl/wsc_sync.sv
module wsc_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("wsc_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/wsc_periph_lane.sv
module wsc_periph_lane
   import wsc_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_mode,
   input  logic              enable,
   input  logic              pin,
   output logic [CODE_W-1:0] mode_rd,
   output logic              irq
);
   // only one legal code exists: any write arms the line at level-high
   logic armed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       armed_q <= 1'b0;
      else if (wr_mode) armed_q <= 1'b1;
   end

   assign mode_rd = armed_q ? SNS_HIGH : SNS_NONE;
   assign irq     = armed_q & enable & pin;
endmodule

// File: rtl/wsc_wake_lane.sv
module wsc_wake_lane
   import wsc_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pin,
   input  logic              enable,
   input  logic              wr_mode,
   input  logic [7:0]        wdata,
   input  logic              clear,
   output logic [CODE_W-1:0] mode_rd,
   output logic              status,
   output logic              level_hit
);
   sense_e mode_q;
   logic   pin_s, pin_d, status_q, edge_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           mode_q <= SNS_NONE;
      else if (wr_mode && code_ok(wdata))   mode_q <= sense_e'(wdata[CODE_W-1:0]);
   end

   wsc_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin),
      .q     (pin_s)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pin_d <= 1'b0;
      else        pin_d <= pin_s;
   end

   always_comb begin
      unique case (mode_q)
         SNS_RISE: edge_hit = pin_s & ~pin_d;
         SNS_FALL: edge_hit = ~pin_s & pin_d;
         SNS_BOTH: edge_hit = pin_s ^ pin_d;
         default:  edge_hit = 1'b0;
      endcase
   end

   // a new event wins over a clear in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  status_q <= 1'b0;
      else if (enable && edge_hit) status_q <= 1'b1;
      else if (clear)              status_q <= 1'b0;
   end

   assign mode_rd   = mode_q;
   assign status    = status_q;
   assign level_hit = enable & (((mode_q == SNS_HIGH) & pin_s) |
                                ((mode_q == SNS_LOW)  & ~pin_s));
endmodule

// File: rtl/wake_sense_ctrl.sv
module wake_sense_ctrl
   import wsc_pkg::*;
#(
   parameter int unsigned NUM_PERIPH  = 3,
   parameter int unsigned NUM_SYSWAKE = 4,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned ADDR_W      = 5
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                reg_wr,
   input  logic [ADDR_W-1:0]   reg_addr,
   input  logic [7:0]          reg_wdata,
   output logic [7:0]          reg_rdata,
   input  logic [LINE_MAX-1:0] periph_in,
   input  logic [LINE_MAX-1:0] syswake_in,
   output logic [LINE_MAX-1:0] periph_irq,
   output logic                syswake_irq,
   output logic                wake_req
);
   localparam logic [LINE_MAX-1:0] P_MASK = LINE_MAX'((1 << NUM_PERIPH) - 1);
   localparam logic [LINE_MAX-1:0] S_MASK = LINE_MAX'((1 << NUM_SYSWAKE) - 1);

   if (NUM_PERIPH > LINE_MAX) begin : g_bad_np
      $error("wake_sense_ctrl: NUM_PERIPH above 8");
   end
   if (NUM_SYSWAKE > LINE_MAX) begin : g_bad_ns
      $error("wake_sense_ctrl: NUM_SYSWAKE above 8");
   end
   if (ADDR_W < 5) begin : g_bad_aw
      $error("wake_sense_ctrl: ADDR_W below 5");
   end

   logic [LINE_MAX-1:0] pen_q, sen_q, sw_status, sw_level;
   logic [CODE_W-1:0]   pmode_rd [LINE_MAX];
   logic [CODE_W-1:0]   smode_rd [LINE_MAX];
   logic                wr_pen, wr_sen, wr_stat;

   assign wr_pen  = reg_wr && (reg_addr == ADDR_W'(A_PEN));
   assign wr_sen  = reg_wr && (reg_addr == ADDR_W'(A_SEN));
   assign wr_stat = reg_wr && (reg_addr == ADDR_W'(A_STAT));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pen_q <= '0;
         sen_q <= '0;
      end else begin
         if (wr_pen) pen_q <= reg_wdata & P_MASK;
         if (wr_sen) sen_q <= reg_wdata & S_MASK;
      end
   end

   for (genvar i = 0; i < LINE_MAX; i++) begin : g_periph
      if (i < NUM_PERIPH) begin : g_on
         logic wr_mode;
         assign wr_mode = reg_wr && (reg_addr == ADDR_W'(A_PMODE + 5'(i)));
         wsc_periph_lane u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_mode (wr_mode),
            .enable  (pen_q[i]),
            .pin     (periph_in[i]),
            .mode_rd (pmode_rd[i]),
            .irq     (periph_irq[i])
         );
      end else begin : g_off
         assign pmode_rd[i]   = '0;
         assign periph_irq[i] = 1'b0;
      end
   end

   for (genvar j = 0; j < LINE_MAX; j++) begin : g_wake
      if (j < NUM_SYSWAKE) begin : g_on
         logic wr_mode;
         assign wr_mode = reg_wr && (reg_addr == ADDR_W'(A_SMODE + 5'(j)));
         wsc_wake_lane #(.SYNC_STAGES(SYNC_STAGES)) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .pin       (syswake_in[j]),
            .enable    (sen_q[j]),
            .wr_mode   (wr_mode),
            .wdata     (reg_wdata),
            .clear     (wr_stat & reg_wdata[j]),
            .mode_rd   (smode_rd[j]),
            .status    (sw_status[j]),
            .level_hit (sw_level[j])
         );
      end else begin : g_off
         assign smode_rd[j]  = '0;
         assign sw_status[j] = 1'b0;
         assign sw_level[j]  = 1'b0;
      end
   end

   always_comb begin
      reg_rdata = '0;
      for (int k = 0; k < LINE_MAX; k++) begin
         if (reg_addr == ADDR_W'(A_PMODE + 5'(k))) reg_rdata = {4'b0, pmode_rd[k]};
         if (reg_addr == ADDR_W'(A_SMODE + 5'(k))) reg_rdata = {4'b0, smode_rd[k]};
      end
      if (reg_addr == ADDR_W'(A_PEN))  reg_rdata = pen_q;
      if (reg_addr == ADDR_W'(A_SEN))  reg_rdata = sen_q;
      if (reg_addr == ADDR_W'(A_STAT)) reg_rdata = sw_status;
   end

   assign syswake_irq = |((sw_status & sen_q) | sw_level);
   assign wake_req    = (|periph_irq) | syswake_irq;
endmodule

// File: rtl/wsc_checker.sv
module wsc_checker
   import wsc_pkg::*;
#(
   parameter int unsigned NUM_PERIPH  = 3,
   parameter int unsigned NUM_SYSWAKE = 4,
   parameter int unsigned ADDR_W      = 5
) (
   input logic                clk,
   input logic                rst_n,
   input logic                reg_wr,
   input logic [ADDR_W-1:0]   reg_addr,
   input logic [LINE_MAX-1:0] periph_in,
   input logic [LINE_MAX-1:0] periph_irq,
   input logic                syswake_irq,
   input logic                wake_req,
   input logic [LINE_MAX-1:0] pen_q,
   input logic [LINE_MAX-1:0] sen_q,
   input logic [LINE_MAX-1:0] sw_status
);
   p_unused_periph_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (periph_irq >> NUM_PERIPH) == '0);

   p_unused_status_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_status >> NUM_SYSWAKE) == '0);

   p_periph_gated_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (periph_irq & ~(periph_in & pen_q)) == '0);

   p_status_needs_en_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_status & ~$past(sw_status) & ~$past(sen_q)) == '0);

   p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(sw_status) & ~sw_status) != '0) |->
         $past(reg_wr && (reg_addr == ADDR_W'(A_STAT))));

   p_quiet_disabled_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (sen_q == '0) |-> !syswake_irq);

   p_wake_on_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (syswake_irq || (periph_irq != '0)) |-> wake_req);

   p_wake_off_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (!syswake_irq && (periph_irq == '0)) |-> !wake_req);
endmodule

bind wake_sense_ctrl wsc_checker #(
   .NUM_PERIPH  (NUM_PERIPH),
   .NUM_SYSWAKE (NUM_SYSWAKE),
   .ADDR_W      (ADDR_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .reg_wr      (reg_wr),
   .reg_addr    (reg_addr),
   .periph_in   (periph_in),
   .periph_irq  (periph_irq),
   .syswake_irq (syswake_irq),
   .wake_req    (wake_req),
   .pen_q       (pen_q),
   .sen_q       (sen_q),
   .sw_status   (sw_status)
);

// File: tb/sim_wake_sense_ctrl.sv
`timescale 1ns/1ps
module sim_wake_sense_ctrl;
   localparam int NP = 5;
   localparam int NS = 6;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       reg_wr;
   logic [4:0] reg_addr;
   logic [7:0] reg_wdata;
   logic [7:0] reg_rdata;
   logic [7:0] periph_in, syswake_in, periph_irq;
   logic       syswake_irq, wake_req;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   wake_sense_ctrl #(.NUM_PERIPH(NP), .NUM_SYSWAKE(NS), .SYNC_STAGES(2), .ADDR_W(5)) u0 (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .periph_in(periph_in),
      .syswake_in(syswake_in), .periph_irq(periph_irq),
      .syswake_irq(syswake_irq), .wake_req(wake_req));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [7:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic settle();
      @(negedge clk);
      #1;
   endtask

   function automatic bit legal(input int v);
      return (v <= 4) || (v == 8);
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [7:0] d;
      logic [7:0] stored;
      int codes[6] = '{0, 1, 2, 3, 4, 8};
      rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
      periph_in = '0; syswake_in = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 / R13: every address reads 0 after reset, outputs low
      for (int a = 0; a < 32; a++) begin
         rd(5'(a), d);
         chk((a > 18) ? "R13 unmapped read" : "R1 reset register", 32'(d), 0);
      end
      settle();
      chk("R1 reset outputs", {22'd0, periph_irq, syswake_irq, wake_req}, 0);

      // R13 / R11: enable masks hold only configured lines
      wr(5'h10, 8'hFF); rd(5'h10, d); chk("R13 R11 periph enable mask", 32'(d), 32'h1F);
      wr(5'h11, 8'hFF); rd(5'h11, d); chk("R13 R11 wake enable mask", 32'(d), 32'h3F);

      // R2 / R3 / R11: peripheral sweep
      for (int i = 0; i < 8; i++) begin
         periph_in = 8'(1 << i);
         settle();
         chk("R2 unarmed line silent", 32'(periph_irq), 0);
         wr(5'(i), 8'(i + 1));
         rd(5'(i), d);
         chk("R3 periph code reads 4", 32'(d), (i < NP) ? 4 : 0);
         settle();
         chk("R2 R11 periph output", 32'(periph_irq), (i < NP) ? (1 << i) : 0);
         chk("R12 wake from periph", 32'(wake_req), (i < NP) ? 1 : 0);
         wr(5'h10, 8'h00); settle();
         chk("R2 disabled periph", 32'(periph_irq), 0);
         wr(5'h10, 8'hFF);
      end
      periph_in = 8'hA5; settle();
      chk("R2 pattern A5", 32'(periph_irq), 32'h05);
      wr(5'h10, 8'h0A); periph_in = 8'hFF; settle();
      chk("R2 pattern enable 0A", 32'(periph_irq), 32'h0A);
      periph_in = 8'h00; wr(5'h10, 8'h00); settle();
      chk("R12 idle wake", 32'(wake_req), 0);

      // R4: code acceptance on wake line 0
      stored = 8'd0;
      for (int c = 0; c < 17; c++) begin
         int v = (c == 16) ? 8'h18 : c;
         wr(5'h08, 8'(v));
         if (legal(v)) stored = 8'(v);
         rd(5'h08, d);
         chk("R4 code accept or reject", 32'(d), 32'(stored));
      end
      wr(5'h08, 8'h00);
      wr(5'h11, 8'h00);

      // R5 R6 R7 R9 R10 R11: every line, every code, enabled and disabled
      for (int j = 0; j < 8; j++) begin
         for (int ci = 0; ci < 6; ci++) begin
            for (int en = 0; en < 2; en++) begin
               int  c    = codes[ci];
               bit  live = (en == 1) && (j < NS);
               int  sexp;
               int  lexp;
               wr(5'(8 + j), 8'(c));
               rd(5'(8 + j), d);
               chk("R4 R11 wake code readback", 32'(d), (j < NS) ? c : 0);
               wr(5'h11, 8'(en << j));
               wr(5'h12, 8'hFF);
               repeat (4) @(negedge clk);
               settle();
               chk("R9 R10 low level", 32'(syswake_irq), (live && c == 8) ? 1 : 0);
               chk("R12 wake follows shared", 32'(wake_req), (live && c == 8) ? 1 : 0);
               @(negedge clk); syswake_in = 8'(1 << j);
               repeat (4) @(negedge clk);
               rd(5'h12, d);
               sexp = (live && (c == 1 || c == 3)) ? (1 << j) : 0;
               lexp = (live && c == 4) ? 1 : 0;
               chk("R5 R7 R10 rise status", 32'(d), 32'(sexp));
               chk("R5 R9 rise output", 32'(syswake_irq), (sexp != 0 || lexp != 0) ? 1 : 0);
               wr(5'h12, 8'hFF); settle();
               chk("R9 high level no latch", 32'(syswake_irq), 32'(lexp));
               syswake_in = 8'h00;
               repeat (4) @(negedge clk);
               rd(5'h12, d);
               sexp = (live && (c == 2 || c == 3)) ? (1 << j) : 0;
               lexp = (live && c == 8) ? 1 : 0;
               chk("R6 R7 R10 fall status", 32'(d), 32'(sexp));
               chk("R6 R9 fall output", 32'(syswake_irq), (sexp != 0 || lexp != 0) ? 1 : 0);
               wr(5'h12, 8'hFF);
               wr(5'(8 + j), 8'h00);
               wr(5'h11, 8'h00);
            end
         end
      end

      // R8: write-one-to-clear per bit
      wr(5'h08, 8'd1); wr(5'h09, 8'd1); wr(5'h11, 8'h03);
      @(negedge clk); syswake_in = 8'h03;
      repeat (4) @(negedge clk);
      rd(5'h12, d); chk("R8 both set", 32'(d), 32'h03);
      wr(5'h12, 8'h01); rd(5'h12, d); chk("R8 clear bit 0 only", 32'(d), 32'h02);
      wr(5'h12, 8'h00); rd(5'h12, d); chk("R8 zero write keeps", 32'(d), 32'h02);
      settle(); chk("R8 sticky output", 32'(syswake_irq), 1);
      syswake_in = 8'h00;
      repeat (4) @(negedge clk);
      rd(5'h12, d); chk("R8 survives pin low", 32'(d), 32'h02);
      wr(5'h12, 8'h02); rd(5'h12, d); chk("R8 clear bit 1", 32'(d), 0);
      settle(); chk("R8 output drops", 32'(syswake_irq), 0);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule